// File: doc/BRIEF.md
# Lookahead Window Cell Scheduler

This block computes, once per time slot, which queued cell each input of an input-queued switch with the same number of inputs and outputs sends through the fabric. Every input exposes a small window holding the destinations of its first few queued cells, with a valid bit for each position. The scheduler works through the window one position per clock cycle. In each round, every input that has not yet been chosen offers the cell at that position. Each offered cell may claim only an output that no earlier round of the same slot has taken. Clashes within a round are settled by a rotating priority. An input that falls behind a blocked head cell can therefore still reach an idle output with a deeper cell, which relaxes strict first-in-first-out service. When the window depth is one, the block degenerates to plain head-of-line service.

A slot is launched with a one-cycle `start`. The window contents must stay stable until `done`. The result is a grant flag per input plus the window position of the granted cell. This result stays on the outputs until the next slot is launched. `done` pulses for one cycle when the last useful round has been registered.

Top module: `lookahead_sched`

## Requirements
- R1: After reset, `grant`, `grantIdx` and `done` are zero, and the rotating priority starts at input 0.
- R2: In a finished slot, each input holds at most one grant, and no two granted inputs' chosen cells carry the same destination.
- R3: Round r examines window position r, for r = 0, 1, 2, ... in that order. Position 0 is the head cell. Only inputs not yet granted take part. A granted input reports r in `grantIdx`, which is field i at bits [i*IdxW +: IdxW].
- R4: A cell offered in a later round cannot win an output that an earlier round of the same slot already assigned.
- R5: Within a round, requesters for one output are searched from the priority pointer upward, wrapping at N, and the first requester found wins. At the end of each slot, the pointer moves to one past the input that won output 0. If output 0 went unassigned, the pointer keeps its value.
- R6: One round takes one clock cycle, and a slot runs at most W rounds. With `start` sampled at edge e0, the round-r result is registered at edge e(r+1). `done` is high for exactly one cycle, right after the final round.
- R7: The slot ends early once every input, or every output, is matched.
- R8: A window position whose valid bit is low is skipped for that input. The valid bit for input i, position k is `winValid[i*W+k]`, and its destination is `winDest[(i*W+k)*DestW +: DestW]`.
- R9: A `start` that arrives while a slot is in progress is ignored.
- R10: The result stays stable from `done` until the next accepted `start`. It reads zero in the cycle after that `start` is accepted.
- R11: With W = 1, only head cells are considered, and a slot always finishes after one round.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch one slot's schedule |
| winValid | input | N*W | Valid bit per window position |
| winDest | input | N*W*DestW | Destination per window position |
| grant | output | N | Input i is granted this slot |
| grantIdx | output | N*IdxW | Window position of each granted cell |
| done | output | 1 | One-cycle pulse when the schedule is final |

## Verification
The final round and early termination can coincide with a pointer update in one cycle. In that cycle the same round may also hand output 0 to a deeper cell. Vectors are therefore built so that output 0 is won in the last round, or in the very round that matches every input. The bench then judges the result by the `done` latency and by which input receives priority in the next slot. A start pulse injected mid-slot checks that the arbiter stays busy and ignores the stray request.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } schedState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic evalEn;
    logic ptrUpd;
  } schedStrobes_t;

  // Status from datapath to control
  typedef struct packed {
    logic allInNext;
    logic allOutNext;
  } schedStatus_t;

endpackage

// File: rtl/sched_rr_arb.sv
module sched_rr_arb #(
  parameter int N = 4,
  localparam int PtrW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  input  logic [PtrW-1:0] base,
  output logic [N-1:0]    gnt
);

  always_comb begin
    logic found;
    gnt   = '0;
    found = 1'b0;
    for (int off = 0; off < N; off++) begin
      int idx;
      idx = int'(base) + off;
      if (idx >= N) idx = idx - N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int W = 4,
  localparam int IdxW = (W > 1) ? $clog2(W) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  schedStatus_t        status,
  output schedStrobes_t       strb,
  output logic [IdxW-1:0]     round,
  output logic                done
);

  localparam logic [IdxW-1:0] LastRound = IdxW'(W - 1);

  schedState_e state;
  logic        finishNow;

  assign finishNow = (round == LastRound) || status.allInNext || status.allOutNext;

  always_comb begin
    strb.clear  = (state == ST_IDLE) && start;
    strb.evalEn = (state == ST_RUN);
    strb.ptrUpd = (state == ST_RUN) && finishNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      round <= '0;
      done  <= 1'b0;
    end else begin
      done <= strb.ptrUpd;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            round <= '0;
          end
        end
        ST_RUN: begin
          if (finishNow) state <= ST_IDLE;
          else           round <= round + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sched_dp.sv
module sched_dp
  import sched_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 4,
  localparam int DestW = (N > 1) ? $clog2(N) : 1,
  localparam int IdxW  = (W > 1) ? $clog2(W) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  schedStrobes_t        strb,
  input  logic [IdxW-1:0]      round,
  input  logic [N*W-1:0]       winValid,
  input  logic [N*W*DestW-1:0] winDest,
  output schedStatus_t         status,
  output logic [N-1:0]         grant,
  output logic [N*IdxW-1:0]    grantIdx
);

  logic [N-1:0]             inMatched, outMatched;
  logic [N-1:0]             curValid, inWin, outAny;
  logic [N-1:0][DestW-1:0]  curDest;
  logic [N-1:0][N-1:0]      req, gnt;
  logic [DestW-1:0]         ptr, owner0, ownerNow, owner0Next, nextPtr;
  logic                     out0Taken, out0TakenNext;

  // Select the window position for the current round
  always_comb begin
    for (int i = 0; i < N; i++) begin
      curValid[i] = winValid[i*W + int'(round)];
      curDest[i]  = winDest[(i*W + int'(round))*DestW +: DestW];
    end
  end

  // Requests: unmatched input, valid cell, free output
  always_comb begin
    for (int o = 0; o < N; o++) begin
      for (int i = 0; i < N; i++) begin
        req[o][i] = !inMatched[i] && curValid[i] &&
                    (curDest[i] == DestW'(o)) && !outMatched[o];
      end
    end
  end

  genvar go;
  generate
    for (go = 0; go < N; go++) begin : g_arb
      sched_rr_arb #(.N(N)) u_arb (
        .req (req[go]),
        .base(ptr),
        .gnt (gnt[go])
      );
    end
  endgenerate

  always_comb begin
    inWin    = '0;
    ownerNow = owner0;
    for (int o = 0; o < N; o++) begin
      outAny[o] = |gnt[o];
      inWin     = inWin | gnt[o];
    end
    for (int i = 0; i < N; i++) begin
      if (gnt[0][i]) ownerNow = DestW'(i);
    end
  end

  assign out0TakenNext     = out0Taken | outAny[0];
  assign owner0Next        = ownerNow;
  assign nextPtr           = (owner0Next == DestW'(N - 1)) ? '0 : owner0Next + 1'b1;
  assign status.allInNext  = &(inMatched | inWin);
  assign status.allOutNext = &(outMatched | outAny);
  assign grant             = inMatched;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inMatched  <= '0;
      outMatched <= '0;
      grantIdx   <= '0;
      out0Taken  <= 1'b0;
      owner0     <= '0;
      ptr        <= '0;
    end else if (strb.clear) begin
      inMatched  <= '0;
      outMatched <= '0;
      grantIdx   <= '0;
      out0Taken  <= 1'b0;
    end else if (strb.evalEn) begin
      inMatched  <= inMatched | inWin;
      outMatched <= outMatched | outAny;
      for (int i = 0; i < N; i++) begin
        if (inWin[i]) grantIdx[i*IdxW +: IdxW] <= round;
      end
      out0Taken <= out0TakenNext;
      owner0    <= owner0Next;
      if (strb.ptrUpd && out0TakenNext) ptr <= nextPtr;
    end
  end

endmodule

// File: rtl/lookahead_sched.sv
module lookahead_sched
  import sched_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 4,
  localparam int DestW = (N > 1) ? $clog2(N) : 1,
  localparam int IdxW  = (W > 1) ? $clog2(W) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [N*W-1:0]       winValid,
  input  logic [N*W*DestW-1:0] winDest,
  output logic [N-1:0]         grant,
  output logic [N*IdxW-1:0]    grantIdx,
  output logic                 done
);

  schedStrobes_t   strb;
  schedStatus_t    status;
  logic [IdxW-1:0] round;

  sched_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .status(status),
    .strb  (strb),
    .round (round),
    .done  (done)
  );

  sched_dp #(.N(N), .W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .round   (round),
    .winValid(winValid),
    .winDest (winDest),
    .status  (status),
    .grant   (grant),
    .grantIdx(grantIdx)
  );

endmodule

// File: rtl/sched_checker.sv
module sched_checker #(
  parameter int N = 4,
  parameter int W = 4,
  localparam int DestW = (N > 1) ? $clog2(N) : 1,
  localparam int IdxW  = (W > 1) ? $clog2(W) : 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 done,
  input logic [N-1:0]         grant,
  input logic [N*IdxW-1:0]    grantIdx,
  input logic [N*W-1:0]       winValid,
  input logic [N*W*DestW-1:0] winDest
);

  logic collide, badValid;

  always_comb begin
    collide  = 1'b0;
    badValid = 1'b0;
    for (int i = 0; i < N; i++) begin
      int ei;
      ei = i*W + int'(grantIdx[i*IdxW +: IdxW]);
      if (grant[i] && !winValid[ei]) badValid = 1'b1;
      for (int j = i + 1; j < N; j++) begin
        int ej;
        ej = j*W + int'(grantIdx[j*IdxW +: IdxW]);
        if (grant[i] && grant[j] &&
            (winDest[ei*DestW +: DestW] == winDest[ej*DestW +: DestW]))
          collide = 1'b1;
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (grant == '0 && !done));

  p_unique_out_r2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !collide);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_grant_valid_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !badValid);

  p_hold_result_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> ($stable(grant) && $stable(grantIdx)));

endmodule

bind lookahead_sched sched_checker #(.N(N), .W(W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .done    (done),
  .grant   (grant),
  .grantIdx(grantIdx),
  .winValid(winValid),
  .winDest (winDest)
);

// File: tb/tb_lookahead_sched.sv
module tb_lookahead_sched;

  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] winValid = '0;
  logic [31:0] winDest = '0;
  logic [3:0]  grant;
  logic [7:0]  grantIdx;
  logic        done;

  logic        start1 = 1'b0;
  logic [3:0]  winValid1 = '0;
  logic [7:0]  winDest1 = '0;
  logic [3:0]  grant1, grantIdx1;
  logic        done1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Vector table: valid, dest, expected grant, expected idx, expected start-to-done cycles
  localparam logic [15:0] VV [NV] = '{16'h1111, 16'h1111, 16'h1111, 16'h3331,
                                      16'h7171, 16'h0002, 16'h0000, 16'hFFFF};
  localparam logic [31:0] VD [NV] = '{32'h0, 32'h0, 32'h03020100, 32'h0C080400,
                                      32'h07032D01, 32'h0, 32'h0, 32'hE4E4E4E4};
  localparam logic [3:0]  EG [NV] = '{4'b0001, 4'b0010, 4'b1111, 4'b1110,
                                      4'b1111, 4'b0001, 4'b0000, 4'b1111};
  localparam logic [7:0]  EI [NV] = '{8'h00, 8'h00, 8'h00, 8'h50,
                                      8'h88, 8'h01, 8'h00, 8'h93};
  localparam int          EC [NV] = '{5, 5, 2, 5, 4, 5, 5, 5};

  always #2.5 clk = ~clk;

  lookahead_sched #(.N(4), .W(4)) dut (
    .clk(clk), .rstN(rstN), .start(start), .winValid(winValid), .winDest(winDest),
    .grant(grant), .grantIdx(grantIdx), .done(done)
  );

  lookahead_sched #(.N(4), .W(1)) dut1 (
    .clk(clk), .rstN(rstN), .start(start1), .winValid(winValid1), .winDest(winDest1),
    .grant(grant1), .grantIdx(grantIdx1), .done(done1)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic runSlot(input int v, input bit pokeStart, output int cnt);
    cnt = 0;
    start = 1'b1;
    while (cnt < 20) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        start = 1'b0;
        check(grant == 4'b0, $sformatf("R10 cleared on start v%0d", v), grant, 0);
      end
      if (pokeStart && cnt == 2) start = 1'b1;
      if (pokeStart && cnt == 3) start = 1'b0;
      if (done) break;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(grant == 4'b0 && grantIdx == 8'b0 && !done, "R1 reset outputs", {grant, grantIdx}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(grant == 4'b0 && !done, "R1 after reset release", grant, 0);

    // Table walk: R2 R3 R4 R5 R6 R7 R8
    // v0 priority from input 0 (R1), v1 rotation (R5), v2 early finish (R7),
    // v3 lookahead past blocked head (R3), v4 taken outputs refused (R4) with early finish,
    // v5 invalid head skipped (R8), v6 empty slot keeps pointer, v7 priority reused (R5)
    for (int v = 0; v < NV; v++) begin
      winValid = VV[v];
      winDest  = VD[v];
      runSlot(v, 1'b0, cnt);
      check(cnt == EC[v], $sformatf("R6 R7 latency v%0d", v), cnt, EC[v]);
      check(grant == EG[v], $sformatf("R2 R4 R5 grant v%0d", v), grant, EG[v]);
      check(grantIdx == EI[v], $sformatf("R3 R8 index v%0d", v), grantIdx, EI[v]);
      @(negedge clk);
      check(!done, $sformatf("R6 done single pulse v%0d", v), done, 0);
    end

    // R10: result held while idle
    repeat (4) @(negedge clk);
    check(grant == EG[NV-1] && grantIdx == EI[NV-1], "R10 result held", {grant, grantIdx}, {EG[NV-1], EI[NV-1]});

    // R9: stray start mid-slot ignored (pointer is 2, all heads to output 0)
    winValid = 16'h1111;
    winDest  = 32'h0;
    runSlot(99, 1'b1, cnt);
    check(cnt == 5, "R9 latency unaffected", cnt, 5);
    check(grant == 4'b0100, "R9 grant", grant, 4'b0100);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      check(!done, "R9 no second slot", done, 0);
    end
    check(grant == 4'b0100, "R9 R10 result unchanged", grant, 4'b0100);

    // R11: window depth one, head cells only
    winValid1 = 4'b0111;
    winDest1  = 8'h20;
    start1 = 1'b1;
    @(posedge clk); @(negedge clk);
    start1 = 1'b0;
    check(!done1, "R11 not done after start", done1, 0);
    @(posedge clk); @(negedge clk);
    check(done1, "R11 done after one round", done1, 1);
    check(grant1 == 4'b0101, "R11 head-only grant", grant1, 4'b0101);
    check(grantIdx1 == 4'b0, "R11 index", grantIdx1, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule